// File: doc/BRIEF.md
# Sequence-Unlocked Watchdog Timer

This block is a watchdog for a slow timebase. A one-cycle pulse on `tick_i`, typically at 32 kHz, advances a 32-bit up-counter. The prescaler can slow that rate by a power of two. If software stops servicing the watchdog, the counter runs past its all-ones value. The block then raises a one-cycle reset request and restarts the count from the load value.

Software cannot start or stop the counter with a single write. It must write a pair of fixed 32-bit keys, in order, to the key register. To service the watchdog, software writes the kick register with any value that differs from the last value stored there.

A status register shows, for each writable register, whether a write to it is still waiting to settle. A pending flag stays set for a fixed number of ticks after each write, which models the delay of a slower clock domain. The host side is a 32-bit register bus with a 4-bit word address and separate read and write strobes.

Top module: `wdt_seq_timer`

## Requirements
- R1: Writing 0x0000BBBB and then 0x00004444 to the key register (address 6) starts the counter.
- R2: Writing 0x0000AAAA and then 0x00005555 to the key register stops the counter. While the counter is stopped, only a kick changes the count.
- R3: A key-register write that is not the expected second word of a sequence returns the sequence detector to idle. The earlier first word is then forgotten.
- R4: A write to the kick register (address 4) whose value differs from the stored kick value copies the load register into the counter. A write of the same value has no effect. The stored kick value resets to 0.
- R5: The control register (address 1) holds the prescaler enable in bit 5 and the prescale exponent in bits 4:2. It reads back exactly those bits.
- R6: While running, the counter increments by one on every tick when the prescaler is disabled. When the prescaler is enabled, it increments once every 2^exponent ticks.
- R7: Writes to the control register and to the load register (address 3) are ignored while the counter is running.
- R8: The revision register (address 0) returns the parameter REV_CODE (default 0x5A) in bits 7:0 and zero above.
- R9: When a running counter steps past 0xFFFFFFFF, `rst_req_o` is high for exactly one cycle and the counter is reloaded from the load register.
- R10: The status register (address 5) shows a pending flag for each writable register: bit 0 for control, bit 2 for load, bit 3 for kick and bit 4 for key. A flag sets on the write and clears after SYNC_TICKS (default 3) further ticks.
- R11: After reset, the counter, load, control, status and `rst_req_o` are all zero, and the counter is stopped. The counter (address 2) can be read at any time. Read data appears on `rdata_o` one cycle after `rd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| addr_i | input | 4 | Register word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request on overflow |

## Verification
The assertions check the following on every cycle:
- A start or stop happens only from the matching armed detector state.
- A stopped counter changes only on a kick.
- Control and load hold their values while the counter runs.
- The reset request lasts one cycle and coincides with a reload.
- Each write raises its own pending flag.

The bench scenarios cover what depends on values rather than on invariants:
- the prescaled count rate;
- a broken key sequence that must not stop the counter;
- the same-value kick that must be ignored;
- the exact cycle of the overflow;
- the tick-by-tick decay of the pending flags.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int EXP_W  = 3;
    localparam int NPEND  = 4;

    localparam logic [ADDR_W-1:0] A_REV  = 4'h0;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h1;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'h2;
    localparam logic [ADDR_W-1:0] A_LOAD = 4'h3;
    localparam logic [ADDR_W-1:0] A_KICK = 4'h4;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h5;
    localparam logic [ADDR_W-1:0] A_KEY  = 4'h6;

    localparam logic [DATA_W-1:0] KEY_ON1  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_ON2  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_OFF1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_OFF2 = 32'h0000_5555;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ON1  = 2'd1,
        SEQ_OFF1 = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic             pre_en;
        logic [EXP_W-1:0] pre_exp;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[5]   = c.pre_en;
        w[4:2] = c.pre_exp;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.pre_en  = w[5];
        c.pre_exp = w[4:2];
        return c;
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
#(
    parameter int EW = EXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          pre_en,
    input  logic [EW-1:0] pre_exp,
    output logic          step
);
    localparam int DIV_W = (1 << EW) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    assign lim    = DIV_W'((32'd1 << pre_exp) - 32'd1);
    assign at_lim = (div_q == lim);
    assign step   = run && tick && (!pre_en || at_lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (tick && pre_en) begin
            div_q <= at_lim ? '0 : div_q + 1'b1;
        end
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (run && pre_en && !tick) |=> (div_q <= lim || !pre_en)) else $error("div range"); // R6

endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              run_o
);
    seq_state_t state_q;
    logic       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            run_q   <= 1'b0;
        end else if (key_wr) begin
            if (state_q == SEQ_ON1 && key_data == KEY_ON2) begin
                run_q   <= 1'b1;
                state_q <= SEQ_IDLE;
            end else if (state_q == SEQ_OFF1 && key_data == KEY_OFF2) begin
                run_q   <= 1'b0;
                state_q <= SEQ_IDLE;
            end else if (key_data == KEY_ON1) begin
                state_q <= SEQ_ON1;
            end else if (key_data == KEY_OFF1) begin
                state_q <= SEQ_OFF1;
            end else begin
                state_q <= SEQ_IDLE;
            end
        end
    end

    assign run_o = run_q;

    AST_START_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(state_q == SEQ_ON1)) else $error("start unarmed"); // R1
    AST_STOP_ARMED: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> $past(state_q == SEQ_OFF1)) else $error("stop unarmed"); // R2
    AST_BAD_KEY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (key_wr && key_data != KEY_ON1 && key_data != KEY_OFF1) |=> state_q == SEQ_IDLE) else $error("seq not idle"); // R3

endmodule

// File: rtl/wdt_pending.sv
module wdt_pending
    import wdt_pkg::*;
#(
    parameter int NREG       = NPEND,
    parameter int SYNC_TICKS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [NREG-1:0] wr_hit,
    output logic [NREG-1:0] pend_o
);
    localparam int CNT_W = $clog2(SYNC_TICKS + 1);

    for (genvar i = 0; i < NREG; i++) begin : g_pend
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (wr_hit[i]) begin
                cnt_q <= CNT_W'(SYNC_TICKS);
            end else if (tick && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign pend_o[i] = (cnt_q != '0);

        AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
            wr_hit[i] |=> pend_o[i]) else $error("pending not set"); // R10
    end

endmodule

// File: rtl/wdt_seq_timer.sv
module wdt_seq_timer
    import wdt_pkg::*;
#(
    parameter logic [7:0] REV_CODE   = 8'h5A,
    parameter int         SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rst_req_o
);
    localparam logic [DATA_W-1:0] CNT_MAX = '1;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] kick_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rst_req_q;
    logic              running;
    logic              step;
    logic              kick_fire;
    logic [NPEND-1:0]  wr_hit;
    logic [NPEND-1:0]  pend;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_mux;

    assign wr_hit[0] = wr_i && addr_i == A_CTRL;
    assign wr_hit[1] = wr_i && addr_i == A_LOAD;
    assign wr_hit[2] = wr_i && addr_i == A_KICK;
    assign wr_hit[3] = wr_i && addr_i == A_KEY;
    assign kick_fire = wr_hit[2] && (wdata_i != kick_q);

    wdt_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr_hit[3]),
        .key_data (wdata_i),
        .run_o    (running)
    );

    wdt_prescale #(.EW(EXP_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .tick    (tick_i),
        .pre_en  (ctrl_q.pre_en),
        .pre_exp (ctrl_q.pre_exp),
        .step    (step)
    );

    wdt_pending #(.NREG(NPEND), .SYNC_TICKS(SYNC_TICKS)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_i),
        .wr_hit (wr_hit),
        .pend_o (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
            kick_q <= '0;
        end else begin
            if (wr_hit[0] && !running) ctrl_q <= word_to_ctrl(wdata_i);
            if (wr_hit[1] && !running) load_q <= wdata_i;
            if (wr_hit[2])             kick_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (kick_fire) begin
                count_q <= load_q;
            end else if (step) begin
                if (count_q == CNT_MAX) begin
                    count_q   <= load_q;
                    rst_req_q <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        stat_word    = '0;
        stat_word[0] = pend[0];
        stat_word[2] = pend[1];
        stat_word[3] = pend[2];
        stat_word[4] = pend[3];
    end

    always_comb begin
        unique case (addr_i)
            A_REV:   rd_mux = {{(DATA_W-8){1'b0}}, REV_CODE};
            A_CTRL:  rd_mux = ctrl_to_word(ctrl_q);
            A_CNT:   rd_mux = count_q;
            A_LOAD:  rd_mux = load_q;
            A_KICK:  rd_mux = kick_q;
            A_STAT:  rd_mux = stat_word;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign rdata_o   = rdata_q;
    assign rst_req_o = rst_req_q;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!running && !kick_fire) |=> $stable(count_q)) else $error("count moved"); // R2
    AST_FROZEN_CFG: assert property (@(posedge clk) disable iff (rst)
        running |=> ($stable(ctrl_q) && $stable(load_q))) else $error("cfg changed"); // R7
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> !rst_req_q) else $error("long reset pulse"); // R9
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |-> (count_q == load_q)) else $error("no reload on wrap"); // R9

endmodule

// File: tb/tb_wdt_seq_timer.sv
module tb_wdt_seq_timer;
    localparam int OP_W = 0;
    localparam int OP_R = 1;
    localparam int OP_T = 2;
    localparam int NV   = 32;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd5, 4'h1, 32'h24,   32'h0},
        '{2'd1, 4'd5, 4'h1, 32'h0,    32'h24},   // R5 fields read back
        '{2'd0, 4'd4, 4'h3, 32'h10,   32'h0},
        '{2'd0, 4'd4, 4'h4, 32'h1,    32'h0},
        '{2'd1, 4'd4, 4'h2, 32'h0,    32'h10},   // R4 kick reload
        '{2'd0, 4'd1, 4'h6, 32'hBBBB, 32'h0},
        '{2'd0, 4'd1, 4'h6, 32'h4444, 32'h0},   // R1 start
        '{2'd2, 4'd6, 4'h0, 32'd4,    32'h0},
        '{2'd1, 4'd6, 4'h2, 32'h0,    32'h12},   // R6 divide by 2
        '{2'd0, 4'd7, 4'h1, 32'h0,    32'h0},
        '{2'd0, 4'd7, 4'h3, 32'h99,   32'h0},
        '{2'd1, 4'd7, 4'h1, 32'h0,    32'h24},   // R7 ctrl frozen
        '{2'd0, 4'd4, 4'h4, 32'h1,    32'h0},
        '{2'd1, 4'd4, 4'h2, 32'h0,    32'h12},   // R4 same value ignored
        '{2'd0, 4'd4, 4'h4, 32'h2,    32'h0},
        '{2'd1, 4'd7, 4'h2, 32'h0,    32'h10},   // R7 load frozen
        '{2'd0, 4'd3, 4'h6, 32'hAAAA, 32'h0},
        '{2'd0, 4'd3, 4'h6, 32'h1234, 32'h0},
        '{2'd0, 4'd3, 4'h6, 32'h5555, 32'h0},
        '{2'd2, 4'd3, 4'h0, 32'd2,    32'h0},
        '{2'd1, 4'd3, 4'h2, 32'h0,    32'h11},   // R3 broken sequence
        '{2'd0, 4'd2, 4'h6, 32'hAAAA, 32'h0},
        '{2'd0, 4'd2, 4'h6, 32'h5555, 32'h0},
        '{2'd2, 4'd2, 4'h0, 32'd4,    32'h0},
        '{2'd1, 4'd2, 4'h2, 32'h0,    32'h11},   // R2 stopped
        '{2'd0, 4'd5, 4'h1, 32'h0,    32'h0},
        '{2'd1, 4'd5, 4'h1, 32'h0,    32'h0},    // R5 accepted when stopped
        '{2'd0, 4'd1, 4'h6, 32'hBBBB, 32'h0},
        '{2'd0, 4'd1, 4'h6, 32'h4444, 32'h0},
        '{2'd2, 4'd6, 4'h0, 32'd3,    32'h0},
        '{2'd1, 4'd6, 4'h2, 32'h0,    32'h14},   // R6 undivided
        '{2'd1, 4'd8, 4'h0, 32'h0,    32'h5A}    // R8 revision
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        rd_i = 1'b0;
    logic [31:0] rdata_o;
    logic        rst_req_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wdt_seq_timer dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .addr_i    (addr_i),
        .wr_i      (wr_i),
        .wdata_i   (wdata_i),
        .rd_i      (rd_i),
        .rdata_o   (rdata_o),
        .rst_req_o (rst_req_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R11 reset state
        check("R11 rst_req", {31'd0, rst_req_o}, 32'd0);
        bus_read(4'h2, v); check("R11 count", v, 32'h0);
        bus_read(4'h5, v); check("R11 status", v, 32'h0);
        bus_read(4'h1, v); check("R11 ctrl", v, 32'h0);

        for (int k = 0; k < NV; k++) begin
            case (int'(VEC[k].op))
                OP_W: bus_write(VEC[k].addr, VEC[k].data);
                OP_R: begin
                    bus_read(VEC[k].addr, v);
                    check($sformatf("R%0d vec %0d", VEC[k].req, k), v, VEC[k].exp);
                end
                OP_T: ticks(int'(VEC[k].data));
                default: ;
            endcase
        end

        // R10 pending flags
        do_reset();
        bus_write(4'h1, 32'h0);
        bus_write(4'h4, 32'h7);
        bus_read(4'h5, v); check("R10 ctrl+kick pend", v, 32'h09);
        bus_write(4'h3, 32'h0);
        bus_write(4'h6, 32'h0);
        bus_read(4'h5, v); check("R10 all pend", v, 32'h1D);
        ticks(2);
        bus_read(4'h5, v); check("R10 still pend", v, 32'h1D);
        ticks(1);
        bus_read(4'h5, v); check("R10 cleared", v, 32'h0);

        // R9 wrap and reset pulse
        do_reset();
        bus_write(4'h3, 32'hFFFF_FFFD);
        bus_write(4'h4, 32'h5);
        bus_write(4'h6, 32'hBBBB);
        bus_write(4'h6, 32'hBBBB);
        bus_write(4'h6, 32'h4444);
        ticks(2);
        bus_read(4'h2, v); check("R9 at max", v, 32'hFFFF_FFFF);
        check("R9 no early pulse", {31'd0, rst_req_o}, 32'd0);
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        check("R9 pulse high", {31'd0, rst_req_o}, 32'd1);
        @(negedge clk);
        check("R9 pulse one cycle", {31'd0, rst_req_o}, 32'd0);
        bus_read(4'h2, v); check("R9 reloaded", v, 32'hFFFF_FFFD);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule